// File: doc/BRIEF.md
# Multi-width 4:2:2 Video Output Formatter

This block takes a 4:2:2 video stream, one pixel per two clock cycles, and drives it onto a 20-bit output port. Each pixel is a luma sample and one chroma sample, with Cb and Cr alternating as supplied upstream. Field, vertical-blanking and horizontal-blanking flags travel with each pixel. At run time it selects one of four lane layouts:

- two interleaved layouts, 8-bit and 10-bit, where chroma and luma share one lane and a new word appears on every clock;
- two side-by-side layouts, 16-bit and 20-bit, where luma and chroma sit on separate lanes and the word changes every second clock.

When embedded codes are on, the block overwrites the blanking pixels on each side of every active region with timing reference codes. Each code is a preamble followed by a status word that carries the field, vertical and horizontal state. Blanking data is forced to black level. Active samples are clipped so that they can never imitate a preamble.

The block runs from the full-rate clock only. An internal phase bit acts as a half-rate clock enable, and the block brings it out as `take_px`. Upstream presents a new pixel on every clock edge where `take_px` is high. A two-pixel lookahead delay line lets a start-of-active code be placed in front of the active region.

Top module: `vid422_fmt`

## Requirements
- R1: While reset is held, `px_out` is 0 and `take_px` is 1. The word after the first clock edge after reset is 20'h10000 (8-bit black luma) whatever `fmt_sel` is, so the format defaults to 8-bit with embedded codes on.
- R2: `take_px` alternates 1, 0, 1, ... from reset. Pixel inputs, `fmt_sel` and `sync_en` are sampled only on edges where `take_px` is 1.
- R3: Format 0 (8-bit): the upper 8 bits of each 10-bit word appear on bits 19:12 and all other bits are 0. For a pixel sampled at edge k, its chroma word appears after edge k+5 and its luma word after edge k+6.
- R4: Format 1 (10-bit): the same chroma-then-luma order and timing as R3, with the 10-bit word on bits 19:10 and bits 9:0 zero.
- R5: Format 2 (16-bit): luma bits 9:2 go on 19:12 and chroma bits 9:2 go on 9:2, with bits 11:10 and 1:0 zero. The word appears after edge k+5 and is held through edge k+6.
- R6: Format 3 (20-bit): luma goes on 19:10 and chroma on 9:0, with the same timing and hold as R5.
- R7: The format is chosen by the 2-bit `fmt_sel` code: 0 is 8-bit, 1 is 10-bit, 2 is 16-bit and 3 is 20-bit.
- R8: With codes on, an end-of-active code replaces the first two blanking pixels after an active run. Chroma and luma of the first pixel carry 3FF and 000; chroma and luma of the second carry 000 and the status word with H=1.
- R9: With codes on, a start-of-active code replaces the two blanking pixels just before an active run. Its words are laid out as in R8, with H=0.
- R10: The status word is {1, F, V, H, V^H, F^H, F^V, F^V^H}, in 8-bit terms, with bit 7 first. It is placed in the upper 8 bits of the 10-bit word, and F and V are taken from the replaced pixel.
- R11: Every other pixel with either blanking flag set is sent as luma 0x040 and chroma 0x200 (10-bit terms).
- R12: Active samples are clamped to the range 0x004 to 0x3FB (10-bit terms).
- R13: With `sync_en` at 0, pixels that would carry codes are sent as black level (R11).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Full-rate pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 2 | Lane layout code (R7) |
| sync_en | input | 1 | Enables embedded timing codes |
| luma_in | input | 10 | Luma sample of the offered pixel |
| chroma_in | input | 10 | Chroma sample (Cb or Cr) of the offered pixel |
| fld_in | input | 1 | Field flag of the offered pixel |
| vblk_in | input | 1 | Vertical-blanking flag of the offered pixel |
| hblk_in | input | 1 | Horizontal-blanking flag of the offered pixel |
| take_px | output | 1 | High on edges that sample a pixel |
| px_out | output | 20 | Formatted output port |

## Verification
The checker assumes that a 3FF chroma word in an interleaved layout can only come from a preamble. That assumption holds only if every blanking and active run lasts at least four pixels, so that end-of-active and start-of-active codes never overlap. The stimulus keeps to this: every line places runs of at least four pixels in each state, and it holds `fmt_sel` and `sync_en` steady between resets. The sweep covers every layout, both code settings, and lines with and without vertical blanking. It includes samples at and beyond both clip limits.

// File: rtl/vid422_pkg.sv
package vid422_pkg;
    localparam int SW = 10;
    localparam int PW = 2 * SW;
    localparam int LSB_PAD = SW - 8;

    typedef enum logic [1:0] {
        FMT_N8  = 2'd0,
        FMT_N10 = 2'd1,
        FMT_W16 = 2'd2,
        FMT_W20 = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        SL_DATA = 2'd0,
        SL_PRE  = 2'd1,
        SL_XY   = 2'd2
    } slot_e;

    typedef struct packed {
        logic [SW-1:0] y;
        logic [SW-1:0] c;
        logic          f;
        logic          v;
        logic          h;
    } pix_t;

    localparam logic [SW-1:0] CLIP_LO = SW'(1 << LSB_PAD);
    localparam logic [SW-1:0] CLIP_HI = SW'((1 << SW) - 1 - (1 << LSB_PAD));
    localparam logic [SW-1:0] Y_BLACK = SW'(16 << LSB_PAD);
    localparam logic [SW-1:0] C_BLACK = SW'(1 << (SW - 1));

    function automatic logic [SW-1:0] clamp_s(input logic [SW-1:0] s);
        if (s < CLIP_LO)      return CLIP_LO;
        else if (s > CLIP_HI) return CLIP_HI;
        else                  return s;
    endfunction

    function automatic logic [7:0] status_b(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction
endpackage

// File: rtl/vid422_tick.sv
module vid422_tick (
    input  logic clk,
    input  logic rst_n,
    output logic take
);
    typedef struct packed {
        logic ph;
    } tick_t;

    tick_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ph = ~st_q.ph;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign take = ~st_q.ph;
endmodule

// File: rtl/vid422_dly.sv
module vid422_dly
    import vid422_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv,
    input  pix_t  px_in,
    output pix_t  px_cur,
    output slot_e slot,
    output logic  h_code
);
    localparam pix_t PIX_IDLE = '{y: '0, c: '0, f: 1'b0, v: 1'b1, h: 1'b1};

    typedef struct packed {
        pix_t s0;
        pix_t s1;
        pix_t s2;
        logic h3;
        logic h4;
    } dly_t;

    dly_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.s0 = px_in;
            st_d.s1 = st_q.s0;
            st_d.s2 = st_q.s1;
            st_d.h3 = st_q.s2.h;
            st_d.h4 = st_q.h3;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s0: PIX_IDLE, s1: PIX_IDLE, s2: PIX_IDLE, h3: 1'b1, h4: 1'b1};
        else        st_q <= st_d;
    end

    always_comb begin
        slot   = SL_DATA;
        h_code = 1'b0;
        if (st_q.s2.h) begin
            if (!st_q.h3) begin
                slot   = SL_PRE;
                h_code = 1'b1;
            end else if (!st_q.h4) begin
                slot   = SL_XY;
                h_code = 1'b1;
            end else if (!st_q.s1.h) begin
                slot   = SL_XY;
            end else if (!st_q.s0.h) begin
                slot   = SL_PRE;
            end
        end
    end

    assign px_cur = st_q.s2;
endmodule

// File: rtl/vid422_map.sv
module vid422_map
    import vid422_pkg::*;
(
    input  pix_t          px,
    input  slot_e         slot,
    input  logic          h_code,
    input  logic          codes_on,
    input  fmt_e          fmt,
    input  logic          want_c,
    output logic [PW-1:0] word
);
    logic [SW-1:0] yv, cv, lane;

    always_comb begin
        if (codes_on && slot == SL_PRE) begin
            cv = '1;
            yv = '0;
        end else if (codes_on && slot == SL_XY) begin
            cv = '0;
            yv = {status_b(px.f, px.v, h_code), {LSB_PAD{1'b0}}};
        end else if (px.h || px.v) begin
            cv = C_BLACK;
            yv = Y_BLACK;
        end else begin
            cv = clamp_s(px.c);
            yv = clamp_s(px.y);
        end
        lane = want_c ? cv : yv;
        case (fmt)
            FMT_N8:  word = {lane[SW-1:LSB_PAD], {(PW-8){1'b0}}};
            FMT_N10: word = {lane, {SW{1'b0}}};
            FMT_W16: word = {yv[SW-1:LSB_PAD], {LSB_PAD{1'b0}},
                             cv[SW-1:LSB_PAD], {LSB_PAD{1'b0}}};
            default: word = {yv, cv};
        endcase
    end
endmodule

// File: rtl/vid422_fmt.sv
module vid422_fmt
    import vid422_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    fmt_sel,
    input  logic          sync_en,
    input  logic [SW-1:0] luma_in,
    input  logic [SW-1:0] chroma_in,
    input  logic          fld_in,
    input  logic          vblk_in,
    input  logic          hblk_in,
    output logic          take_px,
    output logic [PW-1:0] px_out
);
    typedef struct packed {
        fmt_e          fmt;
        logic          emb;
        logic [PW-1:0] out;
    } top_t;

    top_t          st_d, st_q;
    pix_t          px_in, px_cur;
    slot_e         slot;
    logic          h_code;
    logic [PW-1:0] word;
    logic [1:0]    fmt_now;

    assign px_in = '{y: luma_in, c: chroma_in, f: fld_in, v: vblk_in, h: hblk_in};

    vid422_tick u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take_px)
    );

    vid422_dly u_dly (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (take_px),
        .px_in  (px_in),
        .px_cur (px_cur),
        .slot   (slot),
        .h_code (h_code)
    );

    vid422_map u_map (
        .px       (px_cur),
        .slot     (slot),
        .h_code   (h_code),
        .codes_on (st_q.emb),
        .fmt      (st_q.fmt),
        .want_c   (~take_px),
        .word     (word)
    );

    always_comb begin
        st_d = st_q;
        if (take_px) begin
            st_d.fmt = fmt_e'(fmt_sel);
            st_d.emb = sync_en;
        end
        if (!st_q.fmt[1] || !take_px) st_d.out = word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{fmt: FMT_N8, emb: 1'b1, out: '0};
        else        st_q <= st_d;
    end

    assign px_out  = st_q.out;
    assign fmt_now = st_q.fmt;
endmodule

// File: rtl/vid422_chk.sv
module vid422_chk #(
    parameter int PW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          take_px,
    input logic [PW-1:0] px_out,
    input logic [1:0]    fmt_now
);
    AST_TAKE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        take_px |=> !take_px); // R2
    AST_TAKE_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        !take_px |=> take_px); // R2
    AST_N8_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_now == 2'd0) |=> (px_out[PW-9:0] == '0)); // R3
    AST_N10_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_now == 2'd1) |=> (px_out[PW/2-1:0] == '0)); // R4
    AST_W16_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_now == 2'd2 && !take_px) |=> (px_out[PW/2+1:PW/2] == 2'b00 && px_out[1:0] == 2'b00)); // R5
    AST_WIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_now[1] && take_px) |=> $stable(px_out)); // R6
    AST_PRE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (take_px && px_out[PW-1:PW-8] == 8'hFF) |=> (px_out[PW-1:PW-8] == 8'h00)); // R8
endmodule

bind vid422_fmt vid422_chk #(.PW(PW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_px (take_px),
    .px_out  (px_out),
    .fmt_now (fmt_now)
);

// File: tb/test_vid422_fmt.sv
`timescale 1ns/1ps
module test_vid422_fmt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt_sel = 2'd0;
    logic        sync_en = 1'b1;
    logic [9:0]  luma_in = '0;
    logic [9:0]  chroma_in = '0;
    logic        fld_in = 1'b0;
    logic        vblk_in = 1'b0;
    logic        hblk_in = 1'b1;
    logic        take_px;
    logic [19:0] px_out;

    int n_chk = 0;
    int n_fail = 0;
    int ecnt = 0;
    logic [19:0] cap [0:127];

    always #4 clk = ~clk;

    vid422_fmt i_vid422_fmt (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .sync_en(sync_en),
        .luma_in(luma_in), .chroma_in(chroma_in), .fld_in(fld_in),
        .vblk_in(vblk_in), .hblk_in(hblk_in), .take_px(take_px), .px_out(px_out)
    );

    always @(posedge clk) begin
        if (!rst_n) ecnt <= 0;
        else        ecnt <= ecnt + 1;
    end

    always @(negedge clk) if (ecnt < 128) cap[ecnt] <= px_out;

    function automatic logic hb_of(int j);
        if (j < 0 || j > 31) return 1'b1;
        return !((j >= 6 && j <= 13) || (j >= 20 && j <= 23));
    endfunction

    function automatic logic [9:0] y_of(int j);
        if (j == 6) return 10'd0;
        if (j == 7) return 10'd1023;
        return 10'((j * 37 + 100) % 1024);
    endfunction

    function automatic logic [9:0] c_of(int j);
        if (j == 8) return 10'd1022;
        if (j == 9) return 10'd1;
        return 10'((j * 53 + 300) % 1024);
    endfunction

    function automatic logic [9:0] lim(logic [9:0] s);
        if (s < 10'd4)    return 10'd4;
        if (s > 10'd1019) return 10'd1019;
        return s;
    endfunction

    function automatic logic [9:0] stat10(logic f, logic v, logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
    endfunction

    task automatic chk(string req, int edge_i, logic [19:0] act, logic [19:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s edge %0d: got %h expected %h", req, edge_i, act, exp);
        end
    endtask

    task automatic run(logic [1:0] fm, logic emb, logic vb);
        logic f;
        f = fm[0] ^ vb;
        rst_n = 1'b0;
        fmt_sel = fm;
        sync_en = emb;
        hblk_in = 1'b1;
        vblk_in = vb;
        fld_in = f;
        repeat (3) @(negedge clk);
        chk("R1 reset port", 0, px_out, 20'h0);
        chk("R1 reset take", 0, {19'd0, take_px}, 20'h1);
        rst_n = 1'b1;
        for (int j = 0; j < 32; j++) begin
            luma_in = y_of(j);
            chroma_in = c_of(j);
            hblk_in = hb_of(j);
            vblk_in = vb;
            fld_in = f;
            @(posedge clk);
            @(negedge clk);
            @(posedge clk);
            @(negedge clk);
        end
        @(negedge clk);
        chk("R1 default 8-bit black", 1, cap[1], 20'h10000);
        for (int j = 0; j < 28; j++) begin
            logic [9:0] ec, ey;
            string tag;
            logic h = hb_of(j);
            if (emb && h && !hb_of(j - 1)) begin
                ec = 10'h3FF; ey = 10'h000; tag = "R8 end preamble";
            end else if (emb && h && !hb_of(j - 2)) begin
                ec = 10'h000; ey = stat10(f, vb, 1'b1); tag = "R8 R10 end status";
            end else if (emb && h && !hb_of(j + 1)) begin
                ec = 10'h000; ey = stat10(f, vb, 1'b0); tag = "R9 R10 start status";
            end else if (emb && h && !hb_of(j + 2)) begin
                ec = 10'h3FF; ey = 10'h000; tag = "R9 start preamble";
            end else if (h || vb) begin
                ec = 10'h200; ey = 10'h040;
                tag = (!emb && h && (!hb_of(j - 1) || !hb_of(j - 2) || !hb_of(j + 1) || !hb_of(j + 2)))
                      ? "R13 codes off" : "R11 black";
            end else begin
                ec = lim(c_of(j)); ey = lim(y_of(j));
                tag = (j >= 6 && j <= 9) ? "R12 clip" : "R7 active";
            end
            case (fm)
                2'd0: begin
                    chk({tag, " R3 chroma"}, 2*j+6, cap[2*j+6], {ec[9:2], 12'h0});
                    chk({tag, " R3 luma"}, 2*j+7, cap[2*j+7], {ey[9:2], 12'h0});
                end
                2'd1: begin
                    chk({tag, " R4 chroma"}, 2*j+6, cap[2*j+6], {ec, 10'h0});
                    chk({tag, " R4 luma"}, 2*j+7, cap[2*j+7], {ey, 10'h0});
                end
                2'd2: begin
                    chk({tag, " R5 word"}, 2*j+6, cap[2*j+6], {ey[9:2], 2'b00, ec[9:2], 2'b00});
                    chk({tag, " R5 hold"}, 2*j+7, cap[2*j+7], {ey[9:2], 2'b00, ec[9:2], 2'b00});
                end
                default: begin
                    chk({tag, " R6 word"}, 2*j+6, cap[2*j+6], {ey, ec});
                    chk({tag, " R6 hold"}, 2*j+7, cap[2*j+7], {ey, ec});
                end
            endcase
        end
    endtask

    initial begin
        for (int m = 0; m < 4; m++)
            for (int e = 0; e < 2; e++)
                for (int v = 0; v < 2; v++)
                    run(2'(m), 1'(1 - e), 1'(v));
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule